// File: doc/BRIEF.md
# Pipelined Register Slave with Ordered Responses

This block is a small memory-mapped register slave. A master presents one read or one write per cycle, with a word address, write data and per-byte enables. The slave takes the command in any cycle where it is not stalling. It returns exactly one response for each command it takes. Read answers raise a read-data strobe and carry the addressed word. Write answers raise a separate write-response strobe.

Both kinds of answer leave through one queue, so they come back in the order the commands were taken, and never both in the same cycle. The slave stalls the master while that queue is full. A command whose address lies beyond the implemented word count completes with an error code. It touches no storage, and a read of such an address returns zero data.

A lock input is sampled and recorded but does not alter any transfer.

Top module: `mm_resp_slave`

## Requirements
- R1: A command is taken only in a cycle where `cmd_read` or `cmd_write` is high and `stall` is low. `stall` is high exactly while the response queue is full. With a one-entry queue, `stall` is therefore high in the cycle after each taken command.
- R2: Each taken command produces exactly one response, in the cycle after it is taken. A read gives `rd_valid`, and a write gives `wr_resp_valid`. No strobe is raised in any other cycle, and a command held while stalled is answered only once.
- R3: `rd_valid` and `wr_resp_valid` are never high in the same cycle.
- R4: A read returns the word stored at its address at the time it is taken. A write replaces byte i (bits 8i+7..8i) of the addressed word only when `cmd_byte_en[i]` is 1, and leaves the other bytes unchanged.
- R5: `resp_code` is 2'b00 for an address below `WORDS`. It is 2'b11 for an address at or above `WORDS`. Such a command changes no stored word, and such a read returns all-zero data. `rd_data` is zero whenever `rd_valid` is low.
- R6: In the cycle after reset, both strobes and `stall` are low, and every stored word reads as zero.
- R7: Outstanding reads plus outstanding writes stay below `MAX_OUTSTANDING`.
- R8: `stall` never holds a pending command for `MAX_STALL` or more consecutive cycles. No outstanding command waits `MAX_WAIT` or more cycles for its answer.
- R9: `cmd_lock` has no effect on the data, code or timing of any response. The slave records whether the last taken command carried it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_read | input | 1 | Read command present |
| cmd_write | input | 1 | Write command present |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | 32 | Write data |
| cmd_byte_en | input | 4 | Per-byte write enables |
| cmd_lock | input | 1 | Lock request, recorded only |
| stall | output | 1 | Master must hold its command |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| wr_resp_valid | output | 1 | Write response strobe |
| resp_code | output | 2 | 2'b00 okay, 2'b11 error |

## Verification
The properties rely on the master obeying the bus rules. Read and write are never raised together, and every write has a nonzero byte enable. A stalled command stays unchanged until it is taken, and lock rises only together with a command. The bench drives every transfer from tasks that raise one command kind at a time and always use nonzero enables. These tasks hold a stalled command until `stall` drops, and raise lock only alongside a read or a write. Held commands are checked for a single response, using a one-entry queue that forces a stall after every transfer.

// File: rtl/mm_slave_pkg.sv
`timescale 1ns/1ps
package mm_slave_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BE_W-1:0]   be_t;

    typedef enum logic {
        CMD_RD = 1'b0,
        CMD_WR = 1'b1
    } cmd_kind_e;

    typedef enum logic [1:0] {
        RESP_OKAY  = 2'b00,
        RESP_ERROR = 2'b11
    } resp_code_e;

    typedef struct packed {
        cmd_kind_e  kind;
        resp_code_e code;
        word_t      data;
    } resp_entry_t;

    // Replace only the byte lanes whose enable bit is set
    function automatic word_t merge_bytes(word_t old_w, word_t new_w, be_t be);
        word_t res;
        res = old_w;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) res[8*b +: 8] = new_w[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/mm_word_store.sv
`timescale 1ns/1ps
module mm_word_store
    import mm_slave_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    input  be_t              be,
    output word_t            rdata
);

    word_t words [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) words[w] <= '0;
        end else if (we) begin
            words[idx] <= merge_bytes(words[idx], wdata, be);
        end
    end

    assign rdata = words[idx];

endmodule

// File: rtl/mm_cmd_decode.sv
`timescale 1ns/1ps
module mm_cmd_decode
    import mm_slave_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORDS  = 16,
    parameter int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              accept,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             store_rdata,
    output logic              store_we,
    output logic [IDX_W-1:0]  store_idx,
    output resp_entry_t       entry
);

    logic in_range;

    assign in_range  = (int'(addr) < WORDS);
    assign store_idx = addr[IDX_W-1:0];
    assign store_we  = accept && is_write && in_range;

    always_comb begin
        entry.kind = is_write ? CMD_WR : CMD_RD;
        entry.code = in_range ? RESP_OKAY : RESP_ERROR;
        entry.data = (!is_write && in_range) ? store_rdata : '0;
    end

endmodule

// File: rtl/mm_resp_fifo.sv
`timescale 1ns/1ps
module mm_resp_fifo
    import mm_slave_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  resp_entry_t push_entry,
    input  logic        pop,
    output resp_entry_t head,
    output logic        not_empty,
    output logic        full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    resp_entry_t      mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head      = mem[rd_ptr];
    assign not_empty = (count != '0);
    assign full      = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/mm_resp_slave.sv
`timescale 1ns/1ps
module mm_resp_slave
    import mm_slave_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int WORDS      = 16,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_read,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [31:0]       cmd_wdata,
    input  logic [3:0]        cmd_byte_en,
    input  logic              cmd_lock,
    output logic              stall,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              wr_resp_valid,
    output logic [1:0]        resp_code
);

    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic        accept;
    logic        q_full, q_valid;
    logic        store_we;
    logic [IDX_W-1:0] store_idx;
    word_t       store_rdata;
    resp_entry_t new_entry, head;
    logic        lock_held;

    assign accept = (cmd_read || cmd_write) && !q_full;
    assign stall  = q_full;

    mm_cmd_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_decode (
        .accept      (accept),
        .is_write    (cmd_write),
        .addr        (cmd_addr),
        .store_rdata (store_rdata),
        .store_we    (store_we),
        .store_idx   (store_idx),
        .entry       (new_entry)
    );

    mm_word_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .idx   (store_idx),
        .wdata (cmd_wdata),
        .be    (cmd_byte_en),
        .rdata (store_rdata)
    );

    mm_resp_fifo #(.DEPTH(FIFO_DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (accept),
        .push_entry (new_entry),
        .pop        (q_valid),
        .head       (head),
        .not_empty  (q_valid),
        .full       (q_full)
    );

    // Lock is only recorded per taken command
    always_ff @(posedge clk) begin
        if (rst)         lock_held <= 1'b0;
        else if (accept) lock_held <= cmd_lock;
    end

    assign rd_valid      = q_valid && (head.kind == CMD_RD);
    assign wr_resp_valid = q_valid && (head.kind == CMD_WR);
    assign rd_data       = rd_valid ? head.data : '0;
    assign resp_code     = q_valid ? head.code : RESP_OKAY;

endmodule

// File: rtl/mm_resp_slave_checker.sv
`timescale 1ns/1ps
module mm_resp_slave_checker #(
    parameter int MAX_OUTSTANDING = 62,
    parameter int MAX_STALL       = 16,
    parameter int MAX_WAIT        = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_read,
    input logic        cmd_write,
    input logic        cmd_lock,
    input logic        stall,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        wr_resp_valid,
    input logic [1:0]  resp_code,
    input logic        lock_held
);

    logic        take_rd, take_wr;
    logic [15:0] rd_req, rd_ack, wr_req, wr_ack;
    logic [15:0] rd_out, wr_out;
    logic [15:0] stall_cnt, wait_cnt;

    assign take_rd = cmd_read  && !stall;
    assign take_wr = cmd_write && !stall;
    assign rd_out  = rd_req - rd_ack;
    assign wr_out  = wr_req - wr_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_req    <= '0;
            rd_ack    <= '0;
            wr_req    <= '0;
            wr_ack    <= '0;
            stall_cnt <= '0;
            wait_cnt  <= '0;
        end else begin
            if (take_rd)       rd_req <= rd_req + 1'b1;
            if (take_wr)       wr_req <= wr_req + 1'b1;
            if (rd_valid)      rd_ack <= rd_ack + 1'b1;
            if (wr_resp_valid) wr_ack <= wr_ack + 1'b1;
            if ((cmd_read || cmd_write) && stall) stall_cnt <= stall_cnt + 1'b1;
            else                                  stall_cnt <= '0;
            if (rd_valid || wr_resp_valid || take_rd || take_wr) wait_cnt <= '0;
            else if ((rd_out != '0) || (wr_out != '0))           wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_resp_valid));

    assert_no_orphan_read_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_out != '0));

    assert_no_orphan_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_resp_valid |-> (wr_out != '0));

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        take_rd |=> rd_valid);

    assert_write_latency_R2: assert property (@(posedge clk) disable iff (rst)
        take_wr |=> wr_resp_valid);

    assert_quiet_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && !wr_resp_valid && !stall));

    assert_legal_code_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid || wr_resp_valid) |-> (resp_code == 2'b00 || resp_code == 2'b11));

    assert_idle_data_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

    assert_outstanding_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (32'(rd_out) + 32'(wr_out)) < 32'(MAX_OUTSTANDING));

    assert_stall_bound_R8: assert property (@(posedge clk) disable iff (rst)
        32'(stall_cnt) < 32'(MAX_STALL));

    assert_wait_bound_R8: assert property (@(posedge clk) disable iff (rst)
        32'(wait_cnt) < 32'(MAX_WAIT));

    assert_lock_recorded_R9: assert property (@(posedge clk) disable iff (rst)
        ((cmd_read || cmd_write) && !stall) |=> (lock_held == $past(cmd_lock)));

endmodule

bind mm_resp_slave mm_resp_slave_checker #(
    .MAX_OUTSTANDING (62),
    .MAX_STALL       (16),
    .MAX_WAIT        (8)
) u_checker (
    .clk           (clk),
    .rst           (rst),
    .cmd_read      (cmd_read),
    .cmd_write     (cmd_write),
    .cmd_lock      (cmd_lock),
    .stall         (stall),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .wr_resp_valid (wr_resp_valid),
    .resp_code     (resp_code),
    .lock_held     (lock_held)
);

// File: tb/mm_resp_slave_bench.sv
`timescale 1ns/1ps
module mm_resp_slave_bench;

    localparam int ADDR_W = 8;
    localparam int WORDS  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_read = 1'b0;
    logic              cmd_write = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [31:0]       cmd_wdata = '0;
    logic [3:0]        cmd_byte_en = '0;
    logic              cmd_lock = 1'b0;
    logic              stall;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic              wr_resp_valid;
    logic [1:0]        resp_code;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    mm_resp_slave #(.ADDR_W(ADDR_W), .WORDS(WORDS), .FIFO_DEPTH(1)) u_mm_resp_slave (
        .clk           (clk),
        .rst           (rst),
        .cmd_read      (cmd_read),
        .cmd_write     (cmd_write),
        .cmd_addr      (cmd_addr),
        .cmd_wdata     (cmd_wdata),
        .cmd_byte_en   (cmd_byte_en),
        .cmd_lock      (cmd_lock),
        .stall         (stall),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .wr_resp_valid (wr_resp_valid),
        .resp_code     (resp_code)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One command, then the response cycle, then an idle cycle
    task automatic issue(input bit is_rd, input int addr, input logic [31:0] wd,
                         input logic [3:0] be, input bit lk,
                         input logic [1:0] exp_code, input logic [31:0] exp_data,
                         input string req);
        @(negedge clk);
        cmd_read = is_rd; cmd_write = !is_rd; cmd_addr = ADDR_W'(addr);
        cmd_wdata = wd; cmd_byte_en = be; cmd_lock = lk;
        while (stall) @(negedge clk);
        @(negedge clk);
        cmd_read = 1'b0; cmd_write = 1'b0; cmd_lock = 1'b0;
        chk(rd_valid == is_rd, {req, " R2 read strobe"}, 32'(rd_valid), 32'(is_rd));
        chk(wr_resp_valid == !is_rd, {req, " R2 write strobe"}, 32'(wr_resp_valid), 32'(!is_rd));
        chk(!(rd_valid && wr_resp_valid), {req, " R3 exclusive"}, 32'(rd_valid), 32'(0));
        chk(resp_code == exp_code, {req, " code"}, 32'(resp_code), 32'(exp_code));
        if (is_rd) chk(rd_data == exp_data, {req, " data"}, rd_data, exp_data);
        else       chk(rd_data == '0, {req, " R5 idle data"}, rd_data, 32'(0));
        chk(stall == 1'b1, {req, " R1 stall when queue full"}, 32'(stall), 32'(1));
        @(negedge clk);
        chk(!rd_valid && !wr_resp_valid, {req, " R2 no extra response"},
            32'({rd_valid, wr_resp_valid}), 32'(0));
        chk(stall == 1'b0, {req, " R1 stall released"}, 32'(stall), 32'(0));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!rd_valid && !wr_resp_valid, "R6 strobes low", 32'({rd_valid, wr_resp_valid}), 32'(0));
        chk(stall == 1'b0, "R6 stall low", 32'(stall), 32'(0));
        issue(1'b1, 3, '0, 4'hF, 1'b0, 2'b00, 32'h0, "R6 word cleared");
        issue(1'b1, WORDS-1, '0, 4'hF, 1'b0, 2'b00, 32'h0, "R6 top word cleared");
    endtask

    task automatic t_write_read;
        issue(1'b0, 2, 32'hA5A5_1234, 4'hF, 1'b0, 2'b00, '0, "R4 full write");
        issue(1'b1, 2, '0, 4'hF, 1'b0, 2'b00, 32'hA5A5_1234, "R4 readback");
        issue(1'b0, 7, 32'h0102_0304, 4'hF, 1'b0, 2'b00, '0, "R4 second write");
        issue(1'b1, 7, '0, 4'hF, 1'b0, 2'b00, 32'h0102_0304, "R4 second readback");
        issue(1'b1, 2, '0, 4'hF, 1'b0, 2'b00, 32'hA5A5_1234, "R4 first kept");
    endtask

    task automatic t_byte_enable;
        issue(1'b0, 2, 32'hFFFF_FFFF, 4'b0101, 1'b0, 2'b00, '0, "R4 partial write");
        issue(1'b1, 2, '0, 4'hF, 1'b0, 2'b00, 32'hA5FF_12FF, "R4 lanes 0,2 only");
        issue(1'b0, 2, 32'h0000_0000, 4'b1000, 1'b0, 2'b00, '0, "R4 top lane write");
        issue(1'b1, 2, '0, 4'hF, 1'b0, 2'b00, 32'h00FF_12FF, "R4 top lane only");
    endtask

    task automatic t_out_of_range;
        issue(1'b0, 20, 32'hDEAD_BEEF, 4'hF, 1'b0, 2'b11, '0, "R5 bad write code");
        issue(1'b1, 20, '0, 4'hF, 1'b0, 2'b11, 32'h0, "R5 bad read zero");
        issue(1'b1, 4, '0, 4'hF, 1'b0, 2'b00, 32'h0, "R5 alias word untouched");
        issue(1'b1, WORDS, '0, 4'hF, 1'b0, 2'b11, 32'h0, "R5 first bad address");
    endtask

    // Second command held through a stall must be answered once
    task automatic t_back_to_back;
        @(negedge clk);
        cmd_read = 1'b1; cmd_addr = 8'd2; cmd_byte_en = 4'hF;
        @(negedge clk);
        chk(rd_valid && rd_data == 32'h00FF_12FF, "R2 first of pair", rd_data, 32'h00FF_12FF);
        chk(stall == 1'b1, "R1 pair stall", 32'(stall), 32'(1));
        cmd_addr = 8'd20;
        @(negedge clk);
        chk(!rd_valid && !wr_resp_valid, "R2 stalled cmd not answered",
            32'({rd_valid, wr_resp_valid}), 32'(0));
        chk(stall == 1'b0, "R1 pair stall drops", 32'(stall), 32'(0));
        @(negedge clk);
        cmd_read = 1'b0;
        chk(rd_valid && resp_code == 2'b11 && rd_data == '0, "R5 held bad read",
            32'({rd_valid, resp_code}), 32'h7);
        @(negedge clk);
        chk(!rd_valid && !wr_resp_valid, "R2 held cmd answered once",
            32'({rd_valid, wr_resp_valid}), 32'(0));
    endtask

    task automatic t_lock;
        issue(1'b0, 5, 32'h0BAD_F00D, 4'hF, 1'b1, 2'b00, '0, "R9 locked write");
        issue(1'b1, 5, '0, 4'hF, 1'b1, 2'b00, 32'h0BAD_F00D, "R9 locked read");
        issue(1'b1, 5, '0, 4'hF, 1'b0, 2'b00, 32'h0BAD_F00D, "R9 unlocked read");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_byte_enable();
        t_out_of_range();
        t_back_to_back();
        t_lock();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'(1), 32'(0));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule